// File: doc/BRIEF.md
# Tournament Hybrid Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two predictors side by side. The first is a per-branch two-level predictor. Low bits of the branch address pick a private history of that branch's recent outcomes, and that history picks a 3-bit saturating counter. The second is a global predictor: a shift register holding the outcomes of the most recent branches picks a 2-bit saturating counter. A third table of 2-bit counters, also picked by the global history, decides which of the two answers becomes the final guess.

The lookup path is combinational. The fetch stage presents a branch address and receives three bits in the same cycle: the final direction and both component guesses. The pipeline keeps the component guesses with the branch. When the branch resolves, it presents the address, the real outcome and the saved component guesses on the resolve port. The block then trains its counters and shifts both histories. History is updated only at resolve time, with no speculative update.

Top module: `tournament_bp`

## Requirements
- R1: The local history entry is chosen by address bits [LIDX_W+1:2], which is [11:2] by default. Bits [1:0] and all bits above that field have no effect. Each entry holds the last LHIST_W (10) outcomes of the branches that map to it.
- R2: The selected local history indexes a table of 3-bit saturating counters. The local guess `pred_local` is the counter MSB, so values 4..7 mean taken.
- R3: The global history (GHIST_W bits, default 10) indexes a table of 2-bit saturating counters. The global guess `pred_global` is the counter MSB. Bit i of the history is 1 when the branch resolved i+1 resolves ago was taken.
- R4: The same global history indexes a table of 2-bit choice counters. When the choice MSB is 0, `pred_taken` equals `pred_local`. When it is 1, `pred_taken` equals `pred_global`.
- R5: On resolve, the choice counter changes only when `res_local` and `res_global` differ. It moves up when the global guess matched the outcome and down when it did not, saturating at 0 and 3.
- R6: On resolve, the local counter and the global counter used by the branch move up on taken and down on not-taken. They saturate at 7/0 and 3/0 respectively.
- R7: On resolve, the global history and the branch's local history entry both shift left by one and take the outcome as the new LSB. With `res_valid` low, no table or history changes, whatever the other resolve inputs are.
- R8: After reset, all histories are zero. Local counters hold 3, and global and choice counters hold 1 (weakly not taken). All three outputs are therefore 0 for any address.
- R9: When a resolve happens in the same cycle as a lookup, the lookup sees the state before that resolve. The update is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Final direction guess (1 = taken) |
| pred_local | output | 1 | Local component guess, kept for resolve |
| pred_global | output | 1 | Global component guess, kept for resolve |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | Address of the resolving branch |
| res_taken | input | 1 | Real outcome of the resolving branch |
| res_local | input | 1 | Local guess saved at lookup |
| res_global | input | 1 | Global guess saved at lookup |

## Verification
The bench feeds always-taken runs long enough to hit both counter ceilings. A design without saturation would wrap a counter to zero and flip its guess after a single not-taken. Loop-shaped and alternating patterns spread across several addresses force the two component guesses to disagree. This exposes a choice table that trains on agreement, or a final mux with its sense reversed. Addresses that differ only in their alignment bits or their upper bits must share one history, so a wrong index slice shows up as a diverging guess. Idle cycles with garbage on the resolve inputs, plus lookups in the same cycle as a resolve, catch a design that updates without `res_valid` or forwards a fresh update into the current lookup.

// File: rtl/tbp_pkg.sv
// Shared helpers for the tournament branch predictor.
// Assumes counter widths of at most 8 bits.
package tbp_pkg;

    // Saturating step of an up/down counter between 0 and maxv.
    function automatic logic [7:0] sat_step(input logic [7:0] cur,
                                            input logic [7:0] maxv,
                                            input logic       up);
        logic [7:0] res;
        res = cur;
        if (up && (cur != maxv))
            res = cur + 8'd1;
        else if (!up && (cur != 8'd0))
            res = cur - 8'd1;
        return res;
    endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
// Table of saturating counters.
// One combinational read port serves lookup. One read-modify-write port
// serves training. Reset loads the weakly-not-taken value
// (2^(CTR_W-1) - 1) into every entry.
// Assumes CTR_W <= 8.
module tbp_ctr_table #(
    parameter int IDX_W = 10,
    parameter int CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_msb,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CTR_W-1:0] WEAK_NT = CTR_W'((1 << (CTR_W - 1)) - 1);
    localparam logic [CTR_W-1:0] MAXV    = {CTR_W{1'b1}};

    logic [CTR_W-1:0] mem [DEPTH];
    logic [CTR_W-1:0] nxt;

    // Lookup: the MSB of the addressed counter is the guess.
    always_comb rd_msb = mem[rd_idx][CTR_W-1];

    // Training: saturating step of the counter being updated.
    always_comb nxt = CTR_W'(tbp_pkg::sat_step(8'(mem[wr_idx]), 8'(MAXV), wr_up));

    // Storage: reset to weakly not taken, else write back the stepped value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= WEAK_NT;
        end else if (wr_en) begin
            mem[wr_idx] <= nxt;
        end
    end
endmodule

// File: rtl/tbp_hist_table.sv
// Per-branch history table.
// Lookup reads the history of one entry. Update shifts the outcome into
// another entry as its LSB. The pre-shift history of the updated entry
// is also output, so the second-level counter can be trained.
// Reset clears all histories.
module tbp_hist_table #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit,
    output logic [HIST_W-1:0] wr_hist
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] mem [DEPTH];

    // Lookup read of the branch's history.
    always_comb rd_hist = mem[rd_idx];

    // Pre-shift history of the resolving branch.
    always_comb wr_hist = mem[wr_idx];

    // Storage: clear on reset, shift the outcome in on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= {wr_hist[HIST_W-2:0], wr_bit};
        end
    end
endmodule

// File: rtl/tbp_ghr.sv
// Global outcome history register.
// It shifts left and takes each resolved outcome as its LSB.
// Reset clears it.
module tbp_ghr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         in_bit,
    output logic [W-1:0] ghr_q
);
    // History shift on every resolved branch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ghr_q <= '0;
        else if (shift_en)
            ghr_q <= {ghr_q[W-2:0], in_bit};
    end
endmodule

// File: rtl/tournament_bp.sv
// Tournament branch direction predictor.
// A local two-level predictor and a global-history predictor both
// guess. A choice table indexed by global history picks between them.
// Lookup is combinational. Training happens on resolve, with indices
// recomputed from the current (non-speculative) histories.
// Assumes PC_W > LIDX_W + 2.
module tournament_bp #(
    parameter int PC_W    = 32,
    parameter int LIDX_W  = 10,
    parameter int LHIST_W = 10,
    parameter int LCTR_W  = 3,
    parameter int GHIST_W = 10,
    parameter int GCTR_W  = 2,
    parameter int CCTR_W  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic            pred_local,
    output logic            pred_global,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic            res_local,
    input  logic            res_global
);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = LIDX_W + IDX_LO - 1;

    logic [LIDX_W-1:0]  pred_lidx, res_lidx;
    logic [LHIST_W-1:0] pred_lhist, res_lhist;
    logic [GHIST_W-1:0] ghr_q;
    logic               choice_msb;
    logic               choice_en;
    logic               unused_pc_bits;

    // Address slices above the alignment bits pick the local entry.
    always_comb begin
        pred_lidx = pred_pc[IDX_HI:IDX_LO];
        res_lidx  = res_pc[IDX_HI:IDX_LO];
    end

    assign unused_pc_bits = ^{pred_pc[PC_W-1:IDX_HI+1], pred_pc[IDX_LO-1:0],
                              res_pc[PC_W-1:IDX_HI+1], res_pc[IDX_LO-1:0]};

    tbp_hist_table #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lhist (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (pred_lidx),
        .rd_hist (pred_lhist),
        .wr_en   (res_valid),
        .wr_idx  (res_lidx),
        .wr_bit  (res_taken),
        .wr_hist (res_lhist)
    );

    tbp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) u_lctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (pred_lhist),
        .rd_msb (pred_local),
        .wr_en  (res_valid),
        .wr_idx (res_lhist),
        .wr_up  (res_taken)
    );

    tbp_ghr #(.W(GHIST_W)) u_ghr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (res_valid),
        .in_bit   (res_taken),
        .ghr_q    (ghr_q)
    );

    tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) u_gctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ghr_q),
        .rd_msb (pred_global),
        .wr_en  (res_valid),
        .wr_idx (ghr_q),
        .wr_up  (res_taken)
    );

    // Choice trains only when the saved component guesses disagreed.
    always_comb choice_en = res_valid && (res_local != res_global);

    tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(CCTR_W)) u_cctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ghr_q),
        .rd_msb (choice_msb),
        .wr_en  (choice_en),
        .wr_idx (ghr_q),
        .wr_up  (res_global == res_taken)
    );

    // Final guess: choice MSB 0 selects local, 1 selects global.
    always_comb pred_taken = choice_msb ? pred_global : pred_local;
endmodule

// File: rtl/tournament_bp_checker.sv
// Assertions for tournament_bp, bound to every instance.
// It sees the ports plus the global history register.
module tournament_bp_checker #(
    parameter int GHIST_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pred_taken,
    input logic               pred_local,
    input logic               pred_global,
    input logic               res_valid,
    input logic               res_taken,
    input logic [GHIST_W-1:0] ghr
);
    AST_RESET_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!pred_taken && !pred_local && !pred_global)); // R8

    AST_FINAL_FROM_COMPONENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_local == pred_global) |-> (pred_taken == pred_local)); // R4

    AST_GHR_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (ghr[0] == $past(res_taken))
                      && (ghr[GHIST_W-1:1] == $past(ghr[GHIST_W-2:0]))); // R7

    AST_GHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(ghr)); // R7

    AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({pred_taken, pred_local, pred_global})); // R2
endmodule

bind tournament_bp tournament_bp_checker #(.GHIST_W(GHIST_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pred_taken  (pred_taken),
    .pred_local  (pred_local),
    .pred_global (pred_global),
    .res_valid   (res_valid),
    .res_taken   (res_taken),
    .ghr         (ghr_q)
);

// File: tb/tournament_bp_bench.sv
`timescale 1ns/1ps
// Scoreboard bench. Driver tasks compute expected guesses from a
// behavioural model and queue them. A monitor compares them shortly
// after each falling edge.
module tournament_bp_bench;
    localparam int PC_W = 32;
    localparam int LN   = 1024;   // local entries and local counter entries
    localparam int GN   = 1024;   // global and choice entries

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0;
    logic            pred_taken, pred_local, pred_global;
    logic            res_valid = 1'b0;
    logic [PC_W-1:0] res_pc = '0;
    logic            res_taken = 1'b0, res_local = 1'b0, res_global = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    bit    q_fin[$];
    bit    q_lp[$];
    bit    q_gp[$];
    string q_tag[$];

    int lht[LN];
    int lct[LN];
    int gct[GN];
    int cct[GN];
    int ghr;

    always #10 clk = ~clk;   // 50 MHz

    tournament_bp u_tournament_bp (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_local(pred_local), .pred_global(pred_global),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_local(res_local), .res_global(res_global)
    );

    task automatic model_reset();
        for (int i = 0; i < LN; i++) begin lht[i] = 0; lct[i] = 3; end
        for (int i = 0; i < GN; i++) begin gct[i] = 1; cct[i] = 1; end
        ghr = 0;
    endtask

    task automatic model_guess(input logic [PC_W-1:0] pc,
                               output bit fin, output bit lp, output bit gp);
        int li;
        li  = int'((pc >> 2) & 32'(LN - 1));
        lp  = lct[lht[li]] >= 4;
        gp  = gct[ghr] >= 2;
        fin = (cct[ghr] >= 2) ? gp : lp;
    endtask

    task automatic model_update(input logic [PC_W-1:0] pc, input bit t,
                                input bit lp, input bit gp);
        int li, lh;
        li = int'((pc >> 2) & 32'(LN - 1));
        lh = lht[li];
        if (t && lct[lh] < 7) lct[lh]++;
        if (!t && lct[lh] > 0) lct[lh]--;
        if (t && gct[ghr] < 3) gct[ghr]++;
        if (!t && gct[ghr] > 0) gct[ghr]--;
        if (lp != gp) begin
            if (gp == t) begin if (cct[ghr] < 3) cct[ghr]++; end
            else begin if (cct[ghr] > 0) cct[ghr]--; end
        end
        lht[li] = ((lh << 1) | int'(t)) & (LN - 1);
        ghr     = ((ghr << 1) | int'(t)) & (GN - 1);
    endtask

    task automatic push_exp(input logic [PC_W-1:0] pc, input string tag,
                            output bit lp, output bit gp);
        bit fin;
        model_guess(pc, fin, lp, gp);
        q_fin.push_back(fin); q_lp.push_back(lp); q_gp.push_back(gp);
        q_tag.push_back(tag);
    endtask

    // Lookup only; the resolve fields carry garbage with res_valid low.
    task automatic lookup(input logic [PC_W-1:0] pc, input string tag);
        bit lp, gp;
        @(negedge clk);
        push_exp(pc, tag, lp, gp);
        pred_pc    = pc;
        res_valid  = 1'b0;
        res_pc     = pc ^ 32'h5A5;
        res_taken  = ~res_taken;
        res_local  = ~res_local;
        res_global = ~res_global;
    endtask

    // Lookup and resolve of the same branch in one cycle (R9).
    task automatic branch(input logic [PC_W-1:0] pc, input bit t, input string tag);
        bit lp, gp;
        @(negedge clk);
        push_exp(pc, tag, lp, gp);
        pred_pc    = pc;
        res_valid  = 1'b1;
        res_pc     = pc;
        res_taken  = t;
        res_local  = lp;
        res_global = gp;
        model_update(pc, t, lp, gp);
    endtask

    task automatic check(input string tag, input string what, input bit got, input bit exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
        end
    endtask

    // Monitor: pop the queued expectations and compare mid-cycle.
    always @(negedge clk) begin
        #3;
        while (q_fin.size() > 0) begin
            string tg;
            tg = q_tag.pop_front();
            check(tg, "pred_taken",  pred_taken,  q_fin.pop_front());
            check(tg, "pred_local",  pred_local,  q_lp.pop_front());
            check(tg, "pred_global", pred_global, q_gp.pop_front());
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state, all guesses not taken
        lookup(32'h0000_0000, "R8");
        lookup(32'h0000_0ABC, "R8");
        lookup(32'hFFFF_FFFC, "R8");
        // R6, R2, R3: always taken to reach the ceilings, then one not-taken
        for (int i = 0; i < 30; i++) branch(32'h0000_0100, 1'b1, "R6");
        branch(32'h0000_0100, 1'b0, "R6");
        for (int i = 0; i < 4; i++) branch(32'h0000_0100, 1'b1, "R2");
        // R3, R4: loop-shaped pattern T T T N
        for (int i = 0; i < 48; i++) branch(32'h0000_0240, (i % 4) != 3, "R4");
        // R5: two interleaved branches with opposite alternations
        for (int i = 0; i < 60; i++) begin
            branch(32'h0000_0380, i[0], "R5");
            branch(32'h0000_0384, !i[0], "R5");
        end
        // R1: addresses differing only above bit 11 or in bits [1:0] alias
        for (int i = 0; i < 12; i++) begin
            branch(32'h0000_1104, i[1], "R1");
            branch(32'h0007_0107, !i[1], "R1");
            lookup(32'h0000_0105, "R1");
        end
        // R7: idle cycles with garbage resolve fields change nothing
        for (int i = 0; i < 8; i++) lookup(32'h0000_0240, "R7");
        lookup(32'h0000_0100, "R7");
        // R3, R5: mixed pattern over several addresses
        for (int i = 0; i < 80; i++)
            branch(32'(32'h400 + 4 * (i % 5)), ((i * 7) % 3) == 0, "R3");
        // R9: lookup right after a burst of same-cycle resolves
        lookup(32'h0000_0400, "R9");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule